// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the controller side of a two-wire PHY management link. A host hands it one command at a time: a two-bit start code, a two-bit opcode, a five-bit PHY address, a five-bit register address, a two-bit turnaround code and sixteen bits of write data. The host also supplies a clock divide value and a flag that suppresses the preamble. The block derives the management clock MDC from the system clock. It shifts the frame out on the data line through a separate output value and output enable, so a pad can build the tri-state pin. For reads it samples the returned register value, and it reports completion with a one-cycle pulse.

Frame progress is held by a five-state controller. `ST_IDLE` leaves on an accepted start, going to `ST_PRE` when the preamble is enabled and to `ST_CMD` when it is suppressed. `ST_PRE` goes to `ST_CMD` after its 32nd bit, `ST_CMD` goes to `ST_TA` after the 14th command bit, and `ST_TA` goes to `ST_DATA` after the second turnaround bit. `ST_DATA` returns to `ST_IDLE` after the 16th data bit. Each transition is taken on a falling MDC edge. The line value changes with the falling edge and the master samples at the rising edge. A command whose opcode is `10` is a read; every other opcode is sent as a write.

Top module: `mdio_master`

## Requirements
- R1: MDC is high for `div_val` system cycles and low for `div_val` system cycles. `done` rises exactly 2·`div_val`·N cycles after the accepting clock edge, where N is 64 with the preamble and 32 without it, and exactly N rising MDC edges occur in that time.
- R2: With `pre_off` low, the first 32 bits are logic one. With `pre_off` high, the frame starts directly with the start code.
- R3: After the preamble come the start code, the opcode, the PHY address and the register address, each sent most significant bit first.
- R4: On a write (opcode not `10`), the output stays enabled for the whole frame and carries the turnaround code and then the 16 write data bits, MSB first.
- R5: On a read (opcode `10`), the output enable is low from the first turnaround bit to the end of the frame. Sixteen bits sampled on the rising MDC edges of the data phase appear on `rdata`, first bit at the MSB, valid when `done` pulses.
- R6: On a read, `ta_err` is 1 at `done` when the second turnaround bit was sampled as 1, and 0 when it was sampled as 0.
- R7: While `busy` is low, `mdio_oe` is 0 and `mdc` is 0.
- R8: A `cmd_start` that arrives while `busy` is high is ignored: the running frame keeps its bits and no second frame follows.
- R9: A `cmd_start` with `div_val` equal to 0 is rejected: `busy` stays 0 and MDC does not toggle.
- R10: `done` is high for exactly one cycle, and `busy` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | DIV_W | Half-period of MDC in system cycles; 0 blocks starts |
| pre_off | input | 1 | Suppress the 32-bit preamble |
| cmd_start | input | 1 | Start request, one cycle |
| cmd_st | input | 2 | Start code |
| cmd_op | input | 2 | Opcode, `10` read, otherwise write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_ta | input | 2 | Turnaround code driven on writes |
| cmd_wdata | input | 16 | Write data |
| mdio_i | input | 1 | Line value from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line value to drive |
| mdio_oe | output | 1 | Drive enable for the line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| ta_err | output | 1 | Second read turnaround bit was not 0 |

## Verification
The bench builds the block with `DIV_W` = 3, so every nonzero divide value from 1 to 7 can be swept. Each of these is crossed with preamble on and off and with read and write. The short frames at divide 1 make an exhaustive walk of all 32 PHY addresses, each paired with a mirrored register address, cheap to run. A PHY model answers reads and can drive a bad turnaround bit. The same small width also makes the zero divide value a one-line case.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int CMD_BITS   = 14;
    localparam int TA_BITS    = 2;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = PRE_BITS + CMD_BITS + TA_BITS + DATA_BITS;
    localparam int TA_FIRST   = PRE_BITS + CMD_BITS;
    localparam int DATA_FIRST = TA_FIRST + TA_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam logic [1:0] OP_READ = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_CMD,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    typedef struct packed {
        logic [1:0]           st;
        logic [1:0]           op;
        logic [4:0]           phy;
        logic [4:0]           regad;
        logic [1:0]           ta;
        logic [DATA_BITS-1:0] wdata;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             edge_hit;

    always_comb begin
        edge_hit = run && (cnt_q == div - DIV_W'(1));
        rise_stb = edge_hit && !mdc_q;
        fall_stb = edge_hit && mdc_q;
        mdc      = mdc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (edge_hit) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R1: a strobe can only be raised while running with a nonzero divider
    a_r1_strobe_needs_div: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb || fall_stb) |-> (run && div != '0));

    // R1: MDC holds its level between strobes
    a_r1_mdc_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rise_stb && !fall_stb) |=> $stable(mdc_q) || !run);

endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 pre_off,
    input  mdio_cmd_t            cmd,
    input  logic                 rise_stb,
    input  logic                 fall_stb,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 done,
    output logic [DATA_BITS-1:0] rdata,
    output logic                 ta_err
);

    localparam logic [IDX_W-1:0] IDX_PRE_LAST  = IDX_W'(PRE_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_CMD_LAST  = IDX_W'(TA_FIRST - 1);
    localparam logic [IDX_W-1:0] IDX_TA_LAST   = IDX_W'(DATA_FIRST - 1);
    localparam logic [IDX_W-1:0] IDX_DATA_LAST = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_NO_PRE    = IDX_W'(PRE_BITS);

    mdio_state_e              state_q, state_d;
    logic [IDX_W-1:0]         idx_q;
    logic [FRAME_BITS-1:0]    frame_q;
    logic                     is_read_q;
    logic [DATA_BITS-1:0]     rdata_q;
    logic                     err_q;
    logic                     done_q;
    logic                     frame_end;

    assign frame_end = (state_q == ST_DATA) && fall_stb && (idx_q == IDX_DATA_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)                              state_d = pre_off ? ST_CMD : ST_PRE;
            ST_PRE:  if (fall_stb && idx_q == IDX_PRE_LAST)   state_d = ST_CMD;
            ST_CMD:  if (fall_stb && idx_q == IDX_CMD_LAST)   state_d = ST_TA;
            ST_TA:   if (fall_stb && idx_q == IDX_TA_LAST)    state_d = ST_DATA;
            ST_DATA: if (frame_end)                           state_d = ST_IDLE;
            default:                                          state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            frame_q   <= '0;
            is_read_q <= 1'b0;
            rdata_q   <= '0;
            err_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= frame_end;
            if (state_q == ST_IDLE) begin
                if (accept) begin
                    frame_q   <= {{PRE_BITS{1'b1}}, cmd};
                    idx_q     <= pre_off ? IDX_NO_PRE : '0;
                    is_read_q <= (cmd.op == OP_READ);
                    rdata_q   <= '0;
                    err_q     <= 1'b0;
                end
            end else begin
                if (fall_stb) idx_q <= idx_q + IDX_W'(1);
                if (rise_stb && is_read_q) begin
                    if (state_q == ST_TA && idx_q == IDX_TA_LAST) err_q <= mdio_i;
                    if (state_q == ST_DATA) rdata_q <= {rdata_q[DATA_BITS-2:0], mdio_i};
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_o  = busy ? frame_q[IDX_DATA_LAST - idx_q] : 1'b0;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:        mdio_oe = 1'b0;
            ST_PRE, ST_CMD: mdio_oe = 1'b1;
            ST_TA, ST_DATA: mdio_oe = !is_read_q;
            default:        mdio_oe = 1'b0;
        endcase
        done   = done_q;
        rdata  = rdata_q;
        ta_err = err_q;
    end

    // R8: the latched frame does not change while a frame runs
    a_r8_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(frame_q));

    // R10: completion is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: busy has dropped when done is seen
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: once a frame releases the line it stays released until idle
    a_r5_release_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     div_val,
    input  logic                 pre_off,
    input  logic                 cmd_start,
    input  logic [1:0]           cmd_st,
    input  logic [1:0]           cmd_op,
    input  logic [4:0]           cmd_phy,
    input  logic [4:0]           cmd_reg,
    input  logic [1:0]           cmd_ta,
    input  logic [DATA_BITS-1:0] cmd_wdata,
    input  logic                 mdio_i,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] rdata,
    output logic                 ta_err
);

    logic [DIV_W-1:0] div_q;
    logic             accept;
    logic             rise_stb;
    logic             fall_stb;
    mdio_cmd_t        cmd;

    assign accept = cmd_start && !busy && (div_val != '0);

    always_comb begin
        cmd.st    = cmd_st;
        cmd.op    = cmd_op;
        cmd.phy   = cmd_phy;
        cmd.regad = cmd_reg;
        cmd.ta    = cmd_ta;
        cmd.wdata = cmd_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= DIV_W'(1);
        else if (accept) div_q <= div_val;
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div      (div_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .pre_off  (pre_off),
        .cmd      (cmd),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rdata    (rdata),
        .ta_err   (ta_err)
    );

    // R7: idle line is released and MDC parked low
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

    // R9: a zero divider never starts a frame
    a_r9_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy && div_val == '0) |=> !busy);

    // R8: a start during a frame does not restart it
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start && !done) |=> $stable(div_q));

endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;

    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] div_val = 3'd1;
    logic          pre_off = 1'b0;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_st = 2'b01;
    logic [1:0]    cmd_op = 2'b01;
    logic [4:0]    cmd_phy = '0;
    logic [4:0]    cmd_reg = '0;
    logic [1:0]    cmd_ta = 2'b10;
    logic [15:0]   cmd_wdata = '0;
    logic          mdio_i = 1'b1;
    logic          mdc, mdio_o, mdio_oe, busy, done, ta_err;
    logic [15:0]   rdata;

    int total = 0;
    int bad = 0;

    always #5 clk = !clk;

    mdio_master #(.DIV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .pre_off(pre_off),
        .cmd_start(cmd_start), .cmd_st(cmd_st), .cmd_op(cmd_op),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_ta(cmd_ta),
        .cmd_wdata(cmd_wdata), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .busy(busy), .done(done), .rdata(rdata),
        .ta_err(ta_err)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one full transaction with a PHY model answering reads
    task automatic run_frame(input int dv, input bit nopre, input bit rd,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] val, input bit ta_bad,
                             input bit inject);
        logic [63:0] exp_bits;
        int nb, off, rises, mism, c, g, r;
        bit mdc_prev;
        string tag;
        tag = rd ? "R5" : "R4";
        exp_bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10,
                    (rd ? 16'h0000 : val)};
        nb = nopre ? 32 : 64;
        off = nopre ? 32 : 0;
        rises = 0; mism = 0; c = 0; mdc_prev = 1'b0;
        @(negedge clk);
        div_val = DW'(dv); pre_off = nopre; cmd_st = 2'b01;
        cmd_op = rd ? 2'b10 : 2'b01; cmd_phy = phy; cmd_reg = ra;
        cmd_ta = 2'b10; cmd_wdata = rd ? 16'h0 : val;
        mdio_i = 1'b1; cmd_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_start = 1'b0;
        while (!done) begin
            @(negedge clk);
            c++;
            if (inject && c == 17) begin
                cmd_start = 1'b1; cmd_phy = ~phy; cmd_op = 2'b10; pre_off = !nopre;
            end
            if (inject && c == 18) cmd_start = 1'b0;
            if (mdc && !mdc_prev) begin
                g = rises + off;
                if (!rd || g < 46) begin
                    if (!mdio_oe || mdio_o != exp_bits[63-g]) mism++;
                end else if (mdio_oe) mism++;
                rises++;
                r = rises + off - 32;
                if (rd && r == 15) mdio_i = ta_bad;
                else if (rd && r >= 16 && r <= 31) mdio_i = val[31-r];
                else mdio_i = 1'b1;
            end
            mdc_prev = mdc;
            if (c > 2*dv*64 + 40) begin
                check("R1", "frame never completed", 0, 1);
                break;
            end
        end
        check("R1", "cycles to done", c, 2*dv*nb);
        check("R1", "rising MDC edges", rises, nb);
        check(nopre ? "R3" : "R2", "line bits mismatched", mism, 0);
        check(tag, "payload and turnaround bits", mism, 0);
        check("R10", "busy low at done", busy, 0);
        if (rd) begin
            check("R5", "read data", rdata, val);
            check("R6", "turnaround error flag", ta_err, ta_bad);
        end
        @(negedge clk);
        check("R10", "done single cycle", done, 0);
        check("R7", "idle drive enable", mdio_oe, 0);
        check("R7", "idle mdc", mdc, 0);
        if (inject) begin
            for (int k = 0; k < 4*dv + 8; k++) begin
                @(negedge clk);
                if (busy || done) begin
                    check("R8", "restart after ignored start", 1, 0);
                    break;
                end
            end
            check("R8", "no second frame", busy, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7", "reset busy", busy, 0);
        check("R7", "reset oe", mdio_oe, 0);
        check("R7", "reset mdc", mdc, 0);
        check("R10", "reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int dv = 1; dv < 8; dv++)
            for (int np = 0; np < 2; np++)
                for (int rd = 0; rd < 2; rd++)
                    run_frame(dv, np[0], rd[0], 5'(dv*3 + np), 5'(31 - dv*2 - rd),
                              16'hA5C3 ^ 16'(dv*16'h0111 + np*16'h4000 + rd*16'h0808),
                              1'b0, 1'b0);

        for (int a = 0; a < 32; a++)
            run_frame(1, 1'b1, a[0], 5'(a), 5'(31 - a), 16'(a * 16'h0813 + 16'h1234), 1'b0, 1'b0);

        // R6: bad turnaround bit from the PHY
        run_frame(2, 1'b0, 1'b1, 5'd9, 5'd3, 16'hBEEF, 1'b1, 1'b0);
        run_frame(1, 1'b1, 1'b1, 5'd9, 5'd3, 16'h00FF, 1'b1, 1'b0);
        // R6: error flag clears on the next good read
        run_frame(1, 1'b1, 1'b1, 5'd9, 5'd3, 16'hFF00, 1'b0, 1'b0);

        // R8: start pulses in the middle of a frame
        run_frame(2, 1'b0, 1'b0, 5'd17, 5'd22, 16'h5A5A, 1'b0, 1'b1);
        run_frame(3, 1'b1, 1'b1, 5'd30, 5'd1, 16'hC001, 1'b0, 1'b1);

        // R9: zero divide value refuses the start
        @(negedge clk);
        div_val = '0; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        begin
            bit seen;
            seen = 1'b0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (busy || mdc || done) seen = 1'b1;
            end
            check("R9", "activity with zero divider", seen, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule